// File: doc/BRIEF.md
# Loop-Disconnect Pulse Dialer

This block turns dialed digits into the make/break pattern that a rotary-style telephone line expects. Each accepted key code goes into a four-entry queue. A sequencer takes digits from the queue one at a time and opens the line (break, output low) a number of times that depends on the digit and on the selected national counting rule. The line is closed (make, output high) between breaks. Before the first break of each digit there is a pre-digit pause, and an inter-digit pause separates one digit from the next.

The caller chooses the pulse rate (10 or 20 pulses per second), the make/break ratio (40:60 or 33:66) and the counting rule. All timing counts pulses of a 1 ms tick input. A mute output stays active while a digit is being sent, and a busy flag shows that work is in progress or still queued. Going on-hook drops everything at once. A tone-mode input holds the line closed and stops the block from accepting digits, because a separate tone path does the dialing in that mode.

Top module: `pulse_dialer`

## Requirements
- R1: Out of reset, and at any time `off_hook` is 0, `line_o` is 0, `mute_n` is 1 and `busy_o` is 0.
- R2: Make/break times in ms: `rate_sel`=0 (10 pps) gives 40/60 with `ratio_sel`=0 and 33/66 with `ratio_sel`=1. `rate_sel`=1 (20 pps) gives 20/30 and 17/33. A phase of D ms lasts exactly D tick pulses. The value 0 on each select is the default choice.
- R3: A digit starts with a pre-digit pause, line high, that lasts one make time. It is measured from `mute_n` falling to the first break.
- R4: From the end of a digit's last break to the first break of the next queued digit is 800 ticks at 10 pps and 500 ticks at 20 pps.
- R5: Break count per digit d. With `map_sel`=0 or 3: d, and 0 gives 10. With `map_sel`=1: 10-d, and 0 gives 10. With `map_sel`=2: d+1, and 0 gives 1.
- R6: Key codes 0..9 are digits. Codes 10..15 (star, hash, unused) are not queued and cause no breaks, and `busy_o` stays 0.
- R7: `mute_n` is 0 from the start of a digit's pre-digit pause until its inter-digit pause ends. `busy_o` is 1 while a digit is active or queued.
- R8: The queue holds 4 digits. A strobe that arrives while the queue is full (judged before any pop in the same cycle) is dropped.
- R9: When `off_hook` falls, `line_o` goes low at once. On the next edge the block is idle and the queue is flushed. Flushed digits are never sent.
- R10: While `tone_mode` is 1 and off-hook, `line_o` is 1 and key strobes are ignored.
- R11: Phases advance only on tick pulses. Rate, ratio and counting rule are captured when a digit leaves the queue, and later changes do not affect that digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| key_stb | input | 1 | Key code valid strobe |
| key_code | input | 4 | Key code, 0..9 digits |
| rate_sel | input | 1 | 0 = 10 pps, 1 = 20 pps |
| ratio_sel | input | 1 | 0 = 40:60, 1 = 33:66 |
| map_sel | input | 2 | Digit-to-break-count rule |
| tone_mode | input | 1 | 1 = tone dialing, line forced high |
| off_hook | input | 1 | 1 = handset off hook |
| line_o | output | 1 | Line control, 0 = break |
| mute_n | output | 1 | Speech mute, active low |
| busy_o | output | 1 | Digit active or queued |

## Verification
The bench sends single digits under each rate/ratio pair and measures break and make widths and the pre-digit pause in ticks. A timer loaded with the wrong constant, or one that counts clocks instead of ticks, shows up there as a wrong width. Two-digit runs measure the longest high stretch against the inter-digit pause. A design that counted the pause from the start of the next digit, or that added the pre-digit pause on top of it, would give a longer stretch than expected. The bench then fills the queue past its depth, hangs up in mid-train with digits still queued, and switches to tone mode in the middle of a break. In these cases a design that accepted a fifth digit, sent flushed digits after going back off-hook, or let a break reach the line would produce break totals that do not match the expected values.

// File: rtl/dialer_pkg.sv
package dialer_pkg;

   localparam int LEFT_W = 4;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_PRE  = 3'd1,
      PH_BRK  = 3'd2,
      PH_MAK  = 3'd3,
      PH_GAP  = 3'd4
   } phase_e;

   typedef enum logic [1:0] {
      MAP_NORMAL    = 2'd0,
      MAP_TEN_MINUS = 2'd1,
      MAP_PLUS_ONE  = 2'd2,
      MAP_ALIAS     = 2'd3
   } map_e;

   function automatic logic [LEFT_W-1:0] break_count(input logic [3:0] digit,
                                                     input logic [1:0] rule);
      logic [LEFT_W-1:0] n;
      case (map_e'(rule))
         MAP_TEN_MINUS: n = (digit == 4'd0) ? 4'd10 : 4'd10 - digit;
         MAP_PLUS_ONE:  n = digit + 4'd1;
         default:       n = (digit == 4'd0) ? 4'd10 : digit;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/dial_fifo.sv
module dial_fifo #(
   parameter int DATA_W = 4,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [DATA_W-1:0] din,
   input  logic              pop,
   output logic [DATA_W-1:0] dout,
   output logic              empty,
   output logic              full
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (1 << PTR_W) != DEPTH) begin : g_bad_depth
      $error("dial_fifo: DEPTH must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("dial_fifo: DATA_W must be positive");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [CNT_W-1:0]  count;
   logic              do_push, do_pop;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + PTR_W'(1);
         if (do_pop)  rd_ptr <= rd_ptr + PTR_W'(1);
         case ({do_push, do_pop})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   assert_drop_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !flush) |=> full);

endmodule

// File: rtl/dial_timing.sv
module dial_timing #(
   parameter int TIMER_W     = 10,
   parameter int MK_SLOW_STD = 40,
   parameter int BK_SLOW_STD = 60,
   parameter int MK_SLOW_ALT = 33,
   parameter int BK_SLOW_ALT = 66,
   parameter int MK_FAST_STD = 20,
   parameter int BK_FAST_STD = 30,
   parameter int MK_FAST_ALT = 17,
   parameter int BK_FAST_ALT = 33,
   parameter int IDP_SLOW    = 800,
   parameter int IDP_FAST    = 500
) (
   input  logic               rate_sel,
   input  logic               ratio_sel,
   output logic [TIMER_W-1:0] make_ms,
   output logic [TIMER_W-1:0] brk_ms,
   output logic [TIMER_W-1:0] gap_ms
);
   localparam int TMAX = (1 << TIMER_W) - 1;

   if (IDP_SLOW > TMAX || IDP_FAST > TMAX || BK_SLOW_ALT > TMAX) begin : g_bad_range
      $error("dial_timing: durations exceed TIMER_W");
   end
   if (IDP_SLOW <= MK_SLOW_STD || IDP_SLOW <= MK_SLOW_ALT ||
       IDP_FAST <= MK_FAST_STD || IDP_FAST <= MK_FAST_ALT) begin : g_bad_gap
      $error("dial_timing: inter-digit pause must exceed make time");
   end
   if (MK_FAST_ALT < 1 || MK_FAST_STD < 1 || BK_FAST_STD < 1 || BK_FAST_ALT < 1)
   begin : g_bad_zero
      $error("dial_timing: durations must be at least one tick");
   end

   logic [TIMER_W-1:0] idp_ms;

   always_comb begin
      case ({rate_sel, ratio_sel})
         2'b00: begin make_ms = TIMER_W'(MK_SLOW_STD); brk_ms = TIMER_W'(BK_SLOW_STD); end
         2'b01: begin make_ms = TIMER_W'(MK_SLOW_ALT); brk_ms = TIMER_W'(BK_SLOW_ALT); end
         2'b10: begin make_ms = TIMER_W'(MK_FAST_STD); brk_ms = TIMER_W'(BK_FAST_STD); end
         default: begin make_ms = TIMER_W'(MK_FAST_ALT); brk_ms = TIMER_W'(BK_FAST_ALT); end
      endcase
      idp_ms = rate_sel ? TIMER_W'(IDP_FAST) : TIMER_W'(IDP_SLOW);
      gap_ms = idp_ms - make_ms;
   end

endmodule

// File: rtl/dial_seq.sv
module dial_seq
   import dialer_pkg::*;
#(
   parameter int TIMER_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               off_hook,
   input  logic               tick,
   input  logic               q_empty,
   input  logic [3:0]         head_digit,
   input  logic [1:0]         map_sel,
   input  logic [TIMER_W-1:0] make_ms,
   input  logic [TIMER_W-1:0] brk_ms,
   input  logic [TIMER_W-1:0] gap_ms,
   output logic               pop,
   output phase_e             phase
);
   logic [TIMER_W-1:0] cnt, mk_q, bk_q, gp_q;
   logic [LEFT_W-1:0]  left;
   logic               last_tick;

   assign last_tick = tick && (cnt == TIMER_W'(1));
   assign pop = off_hook && !q_empty &&
                ((phase == PH_IDLE) || (phase == PH_GAP && last_tick));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
         left  <= '0;
         mk_q  <= '0;
         bk_q  <= '0;
         gp_q  <= '0;
      end else if (!off_hook) begin
         phase <= PH_IDLE;
         cnt   <= '0;
         left  <= '0;
      end else if (pop) begin
         phase <= PH_PRE;
         cnt   <= make_ms;
         left  <= break_count(head_digit, map_sel);
         mk_q  <= make_ms;
         bk_q  <= brk_ms;
         gp_q  <= gap_ms;
      end else if (phase != PH_IDLE && tick) begin
         if (last_tick) begin
            case (phase)
               PH_PRE: begin phase <= PH_BRK; cnt <= bk_q; end
               PH_BRK: begin
                  if (left == LEFT_W'(1)) begin
                     phase <= PH_GAP;
                     cnt   <= gp_q;
                  end else begin
                     phase <= PH_MAK;
                     cnt   <= mk_q;
                     left  <= left - LEFT_W'(1);
                  end
               end
               PH_MAK:  begin phase <= PH_BRK; cnt <= bk_q; end
               default: begin phase <= PH_IDLE; cnt <= '0; end
            endcase
         end else begin
            cnt <= cnt - TIMER_W'(1);
         end
      end
   end

   assert_break_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_BRK && $past(phase) != PH_BRK) |->
      ($past(phase) == PH_PRE || $past(phase) == PH_MAK));

   assert_tick_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE && !tick && off_hook && !pop) |=> $stable(phase));

   assert_breaks_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_BRK || phase == PH_MAK) |-> left != '0);

endmodule

// File: rtl/pulse_dialer.sv
module pulse_dialer
   import dialer_pkg::*;
#(
   parameter int Q_DEPTH     = 4,
   parameter int TIMER_W     = 10,
   parameter int MK_SLOW_STD = 40,
   parameter int BK_SLOW_STD = 60,
   parameter int MK_SLOW_ALT = 33,
   parameter int BK_SLOW_ALT = 66,
   parameter int MK_FAST_STD = 20,
   parameter int BK_FAST_STD = 30,
   parameter int MK_FAST_ALT = 17,
   parameter int BK_FAST_ALT = 33,
   parameter int IDP_SLOW    = 800,
   parameter int IDP_FAST    = 500
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_1ms,
   input  logic       key_stb,
   input  logic [3:0] key_code,
   input  logic       rate_sel,
   input  logic       ratio_sel,
   input  logic [1:0] map_sel,
   input  logic       tone_mode,
   input  logic       off_hook,
   output logic       line_o,
   output logic       mute_n,
   output logic       busy_o
);
   localparam int DIGIT_W  = 4;
   localparam int MAX_DIGIT = 9;

   logic               accept, q_empty, q_full, q_pop;
   logic [DIGIT_W-1:0] q_head;
   logic [TIMER_W-1:0] make_ms, brk_ms, gap_ms;
   phase_e             phase;

   assign accept = key_stb && off_hook && !tone_mode &&
                   (key_code <= DIGIT_W'(MAX_DIGIT));

   dial_fifo #(.DATA_W(DIGIT_W), .DEPTH(Q_DEPTH)) u_queue (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (!off_hook),
      .push  (accept),
      .din   (key_code),
      .pop   (q_pop),
      .dout  (q_head),
      .empty (q_empty),
      .full  (q_full)
   );

   dial_timing #(
      .TIMER_W(TIMER_W),
      .MK_SLOW_STD(MK_SLOW_STD), .BK_SLOW_STD(BK_SLOW_STD),
      .MK_SLOW_ALT(MK_SLOW_ALT), .BK_SLOW_ALT(BK_SLOW_ALT),
      .MK_FAST_STD(MK_FAST_STD), .BK_FAST_STD(BK_FAST_STD),
      .MK_FAST_ALT(MK_FAST_ALT), .BK_FAST_ALT(BK_FAST_ALT),
      .IDP_SLOW(IDP_SLOW), .IDP_FAST(IDP_FAST)
   ) u_timing (
      .rate_sel  (rate_sel),
      .ratio_sel (ratio_sel),
      .make_ms   (make_ms),
      .brk_ms    (brk_ms),
      .gap_ms    (gap_ms)
   );

   dial_seq #(.TIMER_W(TIMER_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .off_hook   (off_hook),
      .tick       (tick_1ms),
      .q_empty    (q_empty),
      .head_digit (q_head),
      .map_sel    (map_sel),
      .make_ms    (make_ms),
      .brk_ms     (brk_ms),
      .gap_ms     (gap_ms),
      .pop        (q_pop),
      .phase      (phase)
   );

   assign line_o = off_hook && (tone_mode || phase != PH_BRK);
   assign mute_n = (phase == PH_IDLE);
   assign busy_o = (phase != PH_IDLE) || !q_empty;

   assert_onhook_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !off_hook |=> (!busy_o && mute_n));

   assert_mute_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !mute_n |-> busy_o);

   assert_full_unused_R8: assert property (@(posedge clk) disable iff (!rst_n)
      q_full |-> busy_o);

endmodule

// File: tb/pulse_dialer_tb_top.sv
module pulse_dialer_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int TICK_DIV   = 2;
   localparam int WATCHDOG   = 150000;

   logic clk = 0, rst_n = 0, tick_1ms = 0, key_stb = 0;
   logic [3:0] key_code = 0;
   logic rate_sel = 0, ratio_sel = 0, tone_mode = 0, off_hook = 0;
   logic [1:0] map_sel = 0;
   logic line_o, mute_n, busy_o;

   int n_checks = 0, n_fail = 0, cycles = 0;
   string cur_req = "R1";

   pulse_dialer dut_i (
      .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .key_stb(key_stb),
      .key_code(key_code), .rate_sel(rate_sel), .ratio_sel(ratio_sel),
      .map_sel(map_sel), .tone_mode(tone_mode), .off_hook(off_hook),
      .line_o(line_o), .mute_n(mute_n), .busy_o(busy_o));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int ref_breaks(input int d, input int rule);
      if (rule == 1) return (d == 0) ? 10 : 10 - d;
      if (rule == 2) return d + 1;
      return (d == 0) ? 10 : d;
   endfunction

   // behavioural reference: digit queue and a list of signed segments
   int mq[$];
   int segs[$];
   int cur_seg, rem;
   bit act;

   task automatic model_start();
      int d, n, mk, bk, idp;
      d   = mq.pop_front();
      n   = ref_breaks(d, map_sel);
      mk  = rate_sel ? (ratio_sel ? 17 : 20) : (ratio_sel ? 33 : 40);
      bk  = rate_sel ? (ratio_sel ? 33 : 30) : (ratio_sel ? 66 : 60);
      idp = rate_sel ? 500 : 800;
      segs.delete();
      for (int k = 0; k < n; k++) begin
         segs.push_back(-bk);
         segs.push_back((k < n - 1) ? mk : idp - mk);
      end
      cur_seg = mk;
      rem     = mk;
      act     = 1;
   endtask

   always @(posedge clk) begin
      int n0;
      if (!rst_n) begin
         mq.delete(); segs.delete(); act = 0; cur_seg = 0; rem = 0;
      end else if (!off_hook) begin
         mq.delete(); segs.delete(); act = 0; cur_seg = 0; rem = 0;
      end else begin
         n0 = mq.size();
         if (act) begin
            if (tick_1ms) begin
               if (rem == 1) begin
                  if (segs.size() > 0) begin
                     cur_seg = segs.pop_front();
                     rem = (cur_seg < 0) ? -cur_seg : cur_seg;
                  end else begin
                     act = 0;
                     if (mq.size() > 0) model_start();
                  end
               end else rem--;
            end
         end else if (mq.size() > 0) model_start();
         if (key_stb && !tone_mode && key_code <= 9 && n0 < 4)
            mq.push_back(int'(key_code));
      end
   end

   // measurements in ticks, and tick generation
   int tdiv = 0;
   bit prev_line = 0, prev_mute = 1, pre_pending = 0;
   int brk_cnt = 0, brk_run = 0, hi_run = 0, last_brk = 0, last_hi = 0;
   int max_hi = 0, first_pre = 0;

   always @(negedge clk) begin
      bit exp_line, exp_mute, exp_busy;
      if (rst_n) begin
         exp_line = off_hook && (tone_mode || !(act && cur_seg < 0));
         exp_mute = !act;
         exp_busy = act || (mq.size() > 0);
         check(line_o == exp_line, cur_req, "line_o", line_o, exp_line);
         check(mute_n == exp_mute, "R7", "mute_n", mute_n, exp_mute);
         check(busy_o == exp_busy, "R7", "busy_o", busy_o, exp_busy);
      end
      if (!mute_n && prev_mute) begin hi_run = 0; pre_pending = 1; end
      if (prev_line && !line_o && off_hook && !tone_mode) begin
         brk_cnt++;
         last_hi = hi_run;
         if (pre_pending) begin first_pre = hi_run; pre_pending = 0; end
         if (hi_run > max_hi) max_hi = hi_run;
         hi_run = 0; brk_run = 0;
      end
      if (!prev_line && line_o) begin last_brk = brk_run; brk_run = 0; end
      prev_line = line_o;
      prev_mute = mute_n;
      tick_1ms = (tdiv == TICK_DIV - 1);
      tdiv = (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
      if (tick_1ms && off_hook && !tone_mode) begin
         if (line_o) hi_run++; else brk_run++;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      #1;
   endtask

   task automatic send_key(input int code);
      @(posedge clk); #1;
      key_code = 4'(code); key_stb = 1;
      @(posedge clk); #1;
      key_stb = 0;
   endtask

   task automatic cfg(input bit r, input bit q, input int m);
      @(posedge clk); #1;
      rate_sel = r; ratio_sel = q; map_sel = 2'(m);
   endtask

   task automatic wait_idle();
      int guard = 0;
      step(2);
      while (busy_o && guard < 20000) begin step(1); guard++; end
      step(2);
   endtask

   task automatic clear_meas();
      brk_cnt = 0; max_hi = 0; last_hi = 0; last_brk = 0; first_pre = 0;
   endtask

   task automatic one_digit(input bit r, input bit q, input int m, input int d,
                            input int mk, input int bk, input string rq);
      cur_req = rq;
      cfg(r, q, m); clear_meas();
      send_key(d);
      wait_idle();
      check(brk_cnt == ref_breaks(d, m), "R5", "break count", brk_cnt, ref_breaks(d, m));
      check(last_brk == bk, "R2", "break width", last_brk, bk);
      check(first_pre == mk, "R3", "pre-digit pause", first_pre, mk);
      if (ref_breaks(d, m) > 1)
         check(last_hi == mk, "R2", "make width", last_hi, mk);
   endtask

   initial begin
      step(3);
      check(line_o == 0, "R1", "reset line_o", line_o, 0);
      check(mute_n == 1, "R1", "reset mute_n", mute_n, 1);
      check(busy_o == 0, "R1", "reset busy_o", busy_o, 0);
      rst_n = 1;
      step(2);
      check(line_o == 0, "R1", "on-hook line_o", line_o, 0);
      off_hook = 1;
      step(3);

      one_digit(0, 0, 0, 3, 40, 60, "R2");
      one_digit(1, 1, 0, 2, 17, 33, "R2");
      one_digit(1, 0, 0, 5, 20, 30, "R2");
      one_digit(0, 1, 0, 0, 33, 66, "R2");
      one_digit(1, 0, 3, 4, 20, 30, "R5");

      // R4 inter-digit pause at 10 pps, 10-N rule
      cur_req = "R4";
      cfg(0, 0, 1); clear_meas();
      send_key(1); send_key(0);
      wait_idle();
      check(brk_cnt == 19, "R5", "10-N total breaks", brk_cnt, 19);
      check(max_hi == 800, "R4", "slow inter-digit pause", max_hi, 800);

      // R4 at 20 pps, N+1 rule
      cfg(1, 0, 2); clear_meas();
      send_key(9); send_key(0);
      wait_idle();
      check(brk_cnt == 11, "R5", "N+1 total breaks", brk_cnt, 11);
      check(max_hi == 500, "R4", "fast inter-digit pause", max_hi, 500);

      // R6 non-digit codes
      cur_req = "R6";
      cfg(1, 0, 0); clear_meas();
      send_key(10); send_key(11); send_key(15);
      step(1);
      check(busy_o == 0, "R6", "busy after star/hash", busy_o, 0);
      step(100);
      check(brk_cnt == 0, "R6", "breaks after star/hash", brk_cnt, 0);

      // R8 queue overflow
      cur_req = "R8";
      clear_meas();
      send_key(1);
      step(3);
      check(mute_n == 0, "R7", "mute during digit", mute_n, 0);
      for (int i = 0; i < 5; i++) send_key(1);
      wait_idle();
      check(brk_cnt == 5, "R8", "breaks with dropped strobe", brk_cnt, 5);

      // R11 selections captured at digit start
      cur_req = "R11";
      cfg(0, 0, 0); clear_meas();
      send_key(2);
      step(4);
      cfg(1, 1, 1);
      wait_idle();
      check(brk_cnt == 2, "R11", "rule change ignored", brk_cnt, 2);
      check(last_brk == 60, "R11", "ratio change ignored", last_brk, 60);

      // R9 on-hook abort with digits queued
      cur_req = "R9";
      cfg(0, 0, 0); clear_meas();
      send_key(9); send_key(9); send_key(9);
      step(300);
      off_hook = 0;
      step(0);
      check(line_o == 0, "R9", "line_o on hang-up", line_o, 0);
      step(1);
      check(busy_o == 0, "R9", "busy_o after hang-up", busy_o, 0);
      check(mute_n == 1, "R9", "mute_n after hang-up", mute_n, 1);
      off_hook = 1;
      clear_meas();
      step(3000);
      check(brk_cnt == 0, "R9", "flushed digits sent", brk_cnt, 0);

      // R10 tone mode
      cur_req = "R10";
      tone_mode = 1;
      send_key(5);
      step(1);
      check(busy_o == 0, "R10", "strobe in tone mode", busy_o, 0);
      check(line_o == 1, "R10", "line in tone mode", line_o, 1);
      tone_mode = 0;
      send_key(2);
      step(100);
      tone_mode = 1;
      step(1);
      check(line_o == 1, "R10", "line forced high mid-train", line_o, 1);
      wait_idle();
      tone_mode = 0;
      step(5);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule